// File: doc/BRIEF.md
# Three-Channel Timer Host Register Port

This block sits between an 8-bit host bus and three counting channels. A 2-bit address selects one of four locations: locations 0 to 2 are the byte-wide data ports of the three channels, and location 3 takes control words. A control word either programs a channel (how its 16-bit count is accessed a byte at a time, its counting mode and its decimal flag) or freezes that channel's current count so that it can be read back later as two bytes.

Each channel has its own byte sequencer. Data writes are turned into 16-bit reload values and handed to the channel with a single-cycle load strobe. Data reads return bytes of the channel's live count, or of the frozen copy when one is pending. The counters themselves sit outside the block. It only reads their live count and drives their reload value, mode and decimal flag.

Top module: `tmr_host_port`

## Requirements
- R1: After reset every channel reports mode 3, decimal flag 0 and reload value 0x0000 (meaning a full 65536 count), with no load strobe active. Its access type is low-byte-only.
- R2: A write to address 3 is a control word with channel select in bits 7:6, access type in bits 5:4, mode in bits 3:1 and decimal flag in bit 0. For access types 1 to 3, the selected channel's mode and flag outputs change on the next cycle. A control write never raises a load strobe, and only a control write changes a mode output.
- R3: A control word whose channel select is 3 changes no output and no channel's access type.
- R4: With access type 1 (low byte only), a data write loads {0x00, byte}. The target channel's strobe is high for exactly the one cycle after the write, and never more than one strobe is high at a time.
- R5: With access type 2 (high byte only), a data write loads {byte, 0x00}.
- R6: With access type 3 (word), the first data write raises no strobe and the second loads {second byte, first byte}. The write sequence then starts over with a low byte.
- R7: Live reads return the live count's low byte every time under access type 1, and its high byte every time under access type 2. Under access type 3 they alternate low, high, starting with low after programming.
- R8: A control word with access type 0 copies the selected channel's live count in its write cycle and leaves mode and flag unchanged. The next two reads of that channel return the copy's low byte and then its high byte, whatever the live count does meanwhile.
- R9: Once the second frozen byte has been read, reads of that channel return the live count again under its programmed access type. The word-mode read order continues where it stood before the freeze.
- R10: A read of address 3 returns 0xFF and changes no sequencing state.
- R11: Programming a channel with access type 1 to 3 discards a pending frozen count and restarts both the word-mode write order and the word-mode read order at the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Location: 0..2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe for one cycle; sequencing advances at the clock edge |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high |
| ch_count | input | NUM_CH*16 | Live counts of the channels, channel 0 in the low bits |
| ld_strobe | output | NUM_CH | One-cycle load request per channel |
| ld_value | output | NUM_CH*16 | Reload value per channel, 0 meaning 65536 |
| ch_mode | output | NUM_CH*3 | Programmed counting mode per channel |
| ch_bcd | output | NUM_CH | Programmed decimal flag per channel |

## Verification
The checker watches, on every cycle, that a load strobe follows only a data write to that channel and that strobes are never more than one-hot. It also checks that control writes never load, that mode outputs move only after a control write and stay put after a freeze command or a channel-3 select, and that address 3 always reads 0xFF. The byte order is left to the bench scenarios: how reload values are assembled, which byte a live read returns, the two-byte frozen read and the return to live reads after it, and the reset of the sequencers on reprogramming. Those depend on sequences of accesses that the bench replays against a model of the counts it drives.

// File: rtl/tmr_hostif_pkg.sv
// Package: shared types for the timer host register port.
// Assumes an 8-bit control word with the field positions listed in ctrl_t.
package tmr_hostif_pkg;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'd0,
        ACC_LO     = 2'd1,
        ACC_HI     = 2'd2,
        ACC_WORD   = 2'd3
    } acc_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_t;

    localparam logic [2:0] MODE_AT_RESET = 3'd3;
    localparam logic [1:0] CTRL_LOC      = 2'd3;
    localparam logic [7:0] CTRL_RD_VALUE = 8'hFF;

endpackage

// File: rtl/tmr_ctrl_dec.sv
// Module: tmr_ctrl_dec
// Splits host accesses into per-channel enables: program, freeze, data
// write and data read. Assumes bus_wr and bus_rd are never high together.
module tmr_ctrl_dec
    import tmr_hostif_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [NUM_CH-1:0] cfg_we,
    output logic [NUM_CH-1:0] frz_we,
    output logic [NUM_CH-1:0] dat_we,
    output logic [NUM_CH-1:0] dat_rd,
    output acc_e              cfg_acc,
    output logic [2:0]        cfg_mode,
    output logic              cfg_bcd
);

    ctrl_t ctl;
    logic  ctl_wr;

    // Purpose: view the write data as a control word.
    assign ctl      = ctrl_t'(bus_wdata);
    assign ctl_wr   = bus_wr && (bus_addr == CTRL_LOC);
    assign cfg_acc  = ctl.acc;
    assign cfg_mode = ctl.mode;
    assign cfg_bcd  = ctl.bcd;

    // Purpose: one set of enables per channel; select value 3 matches none.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign cfg_we[i] = ctl_wr && (ctl.sel == 2'(i)) && (ctl.acc != ACC_FREEZE);
        assign frz_we[i] = ctl_wr && (ctl.sel == 2'(i)) && (ctl.acc == ACC_FREEZE);
        assign dat_we[i] = bus_wr && (bus_addr == 2'(i));
        assign dat_rd[i] = bus_rd && (bus_addr == 2'(i));
    end

endmodule

// File: rtl/tmr_chan_seq.sv
// Module: tmr_chan_seq
// Byte sequencer for one channel: holds access type, mode and flag,
// assembles reload values, freezes the count and picks the read byte.
// Assumes at most one of cfg_we, frz_we, dat_we, dat_rd per cycle.
module tmr_chan_seq
    import tmr_hostif_pkg::*;
#(
    parameter int DW = 8,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          frz_we,
    input  logic          dat_we,
    input  logic          dat_rd,
    input  acc_e          cfg_acc,
    input  logic [2:0]    cfg_mode,
    input  logic          cfg_bcd,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] live_cnt,
    output logic [DW-1:0] rdata,
    output logic          ld_stb,
    output logic [CW-1:0] ld_val,
    output logic [2:0]    mode_o,
    output logic          bcd_o
);

    acc_e          acc_q;
    logic [2:0]    mode_q;
    logic          bcd_q;
    logic          wr_hi_q;
    logic          rd_hi_q;
    logic          frz_armed_q;
    logic          frz_hi_q;
    logic [CW-1:0] frz_q;
    logic [DW-1:0] hold_q;
    logic          ld_stb_q;
    logic [CW-1:0] ld_val_q;

    // Purpose: programming, freeze capture and byte-order toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= ACC_LO;
            mode_q      <= MODE_AT_RESET;
            bcd_q       <= 1'b0;
            wr_hi_q     <= 1'b0;
            rd_hi_q     <= 1'b0;
            frz_armed_q <= 1'b0;
            frz_hi_q    <= 1'b0;
            frz_q       <= '0;
            hold_q      <= '0;
        end else begin
            if (cfg_we) begin
                acc_q       <= cfg_acc;
                mode_q      <= cfg_mode;
                bcd_q       <= cfg_bcd;
                wr_hi_q     <= 1'b0;
                rd_hi_q     <= 1'b0;
                frz_armed_q <= 1'b0;
                frz_hi_q    <= 1'b0;
            end else if (frz_we) begin
                frz_q       <= live_cnt;
                frz_armed_q <= 1'b1;
                frz_hi_q    <= 1'b0;
            end
            if (dat_we && (acc_q == ACC_WORD)) begin
                if (!wr_hi_q) begin
                    hold_q <= wdata;
                end
                wr_hi_q <= !wr_hi_q;
            end
            if (dat_rd) begin
                if (frz_armed_q) begin
                    frz_hi_q <= !frz_hi_q;
                    if (frz_hi_q) begin
                        frz_armed_q <= 1'b0;
                    end
                end else if (acc_q == ACC_WORD) begin
                    rd_hi_q <= !rd_hi_q;
                end
            end
        end
    end

    // Purpose: build the reload value and pulse the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_stb_q <= 1'b0;
            ld_val_q <= '0;
        end else begin
            ld_stb_q <= 1'b0;
            if (dat_we) begin
                unique case (acc_q)
                    ACC_LO: begin
                        ld_stb_q <= 1'b1;
                        ld_val_q <= {{DW{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        ld_stb_q <= 1'b1;
                        ld_val_q <= {wdata, {DW{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (wr_hi_q) begin
                            ld_stb_q <= 1'b1;
                            ld_val_q <= {wdata, hold_q};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Purpose: choose the byte a read of this channel returns.
    always_comb begin
        if (frz_armed_q) begin
            rdata = frz_hi_q ? frz_q[CW-1:DW] : frz_q[DW-1:0];
        end else begin
            unique case (acc_q)
                ACC_HI:   rdata = live_cnt[CW-1:DW];
                ACC_WORD: rdata = rd_hi_q ? live_cnt[CW-1:DW] : live_cnt[DW-1:0];
                default:  rdata = live_cnt[DW-1:0];
            endcase
        end
    end

    assign ld_stb = ld_stb_q;
    assign ld_val = ld_val_q;
    assign mode_o = mode_q;
    assign bcd_o  = bcd_q;

endmodule

// File: rtl/tmr_rd_mux.sv
// Module: tmr_rd_mux
// Selects the read byte by address; the control location and any address
// without a channel return the fixed control read value.
module tmr_rd_mux
    import tmr_hostif_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 8
) (
    input  logic [1:0]           bus_addr,
    input  logic [NUM_CH*DW-1:0] ch_rdata,
    output logic [DW-1:0]        bus_rdata
);

    // Purpose: address-indexed byte select with a fixed default.
    always_comb begin
        bus_rdata = DW'(CTRL_RD_VALUE);
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == 2'(i)) begin
                bus_rdata = ch_rdata[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/tmr_host_port.sv
// Module: tmr_host_port
// Host register port for up to three timer channels: control word decode,
// per-channel byte sequencing and read selection.
// Assumes NUM_CH <= 3 and that reads and writes never share a cycle.
module tmr_host_port
    import tmr_hostif_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 8,
    localparam int CW    = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_rd,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NUM_CH*CW-1:0] ch_count,
    output logic [NUM_CH-1:0]    ld_strobe,
    output logic [NUM_CH*CW-1:0] ld_value,
    output logic [NUM_CH*3-1:0]  ch_mode,
    output logic [NUM_CH-1:0]    ch_bcd
);

    logic [NUM_CH-1:0]    cfg_we;
    logic [NUM_CH-1:0]    frz_we;
    logic [NUM_CH-1:0]    dat_we;
    logic [NUM_CH-1:0]    dat_rd;
    acc_e                 cfg_acc;
    logic [2:0]           cfg_mode;
    logic                 cfg_bcd;
    logic [NUM_CH*DW-1:0] ch_rdata;

    // Purpose: decode host accesses into per-channel enables.
    tmr_ctrl_dec #(.NUM_CH(NUM_CH)) u_dec (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .cfg_we    (cfg_we),
        .frz_we    (frz_we),
        .dat_we    (dat_we),
        .dat_rd    (dat_rd),
        .cfg_acc   (cfg_acc),
        .cfg_mode  (cfg_mode),
        .cfg_bcd   (cfg_bcd)
    );

    // Purpose: one byte sequencer per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_seq
        tmr_chan_seq #(.DW(DW)) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[i]),
            .frz_we   (frz_we[i]),
            .dat_we   (dat_we[i]),
            .dat_rd   (dat_rd[i]),
            .cfg_acc  (cfg_acc),
            .cfg_mode (cfg_mode),
            .cfg_bcd  (cfg_bcd),
            .wdata    (bus_wdata),
            .live_cnt (ch_count[i*CW +: CW]),
            .rdata    (ch_rdata[i*DW +: DW]),
            .ld_stb   (ld_strobe[i]),
            .ld_val   (ld_value[i*CW +: CW]),
            .mode_o   (ch_mode[i*3 +: 3]),
            .bcd_o    (ch_bcd[i])
        );
    end

    // Purpose: return the addressed byte.
    tmr_rd_mux #(.NUM_CH(NUM_CH), .DW(DW)) u_rmux (
        .bus_addr  (bus_addr),
        .ch_rdata  (ch_rdata),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/tmr_host_port_chk.sv
// Module: tmr_host_port_chk
// Cycle-level properties of the host port, bound to tmr_host_port.
// Assumes the synchronous active-low reset of the design.
module tmr_host_port_chk #(
    parameter int NUM_CH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [7:0]          bus_rdata,
    input logic [1:0]          ctl_sel,
    input logic [1:0]          ctl_acc,
    input logic [NUM_CH-1:0]   ld_strobe,
    input logic [NUM_CH*3-1:0] ch_mode,
    input logic [NUM_CH-1:0]   ch_bcd
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_stb
        AST_STB_AFTER_DATA_WR: assert property (@(posedge clk) disable iff (!rst_n)
            ld_strobe[i] |-> $past(bus_wr && (bus_addr == 2'(i)))); // R4
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_strobe)); // R4

    AST_CTRL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 2'd3)) |=> (ld_strobe == '0)); // R2

    AST_MODE_BY_CTRL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_mode) |-> $past(bus_wr && (bus_addr == 2'd3))); // R2

    AST_SEL3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 2'd3) && (ctl_sel == 2'd3)) |=> ($stable(ch_mode) && $stable(ch_bcd))); // R3

    AST_FREEZE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 2'd3) && (ctl_acc == 2'd0)) |=> ($stable(ch_mode) && $stable(ch_bcd))); // R8

    AST_CTRL_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 2'd3)) |-> (bus_rdata == 8'hFF)); // R10

endmodule

bind tmr_host_port tmr_host_port_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ctl_sel   (bus_wdata[7:6]),
    .ctl_acc   (bus_wdata[5:4]),
    .ld_strobe (ld_strobe),
    .ch_mode   (ch_mode),
    .ch_bcd    (ch_bcd)
);

// File: tb/tmr_host_port_tb.sv
module tmr_host_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_rdata;
    logic [15:0]       cnt [NCH];
    logic [NCH*16-1:0] ch_count;
    logic [NCH-1:0]    ld_strobe;
    logic [NCH*16-1:0] ld_value;
    logic [NCH*3-1:0]  ch_mode;
    logic [NCH-1:0]    ch_bcd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  exp_rd  [$];
    string       rd_tag  [$];
    logic [1:0]  exp_ldc [$];
    logic [15:0] exp_ldv [$];
    string       ld_tag  [$];

    assign ch_count = {cnt[2], cnt[1], cnt[0]};

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_host_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .ch_count  (ch_count),
        .ld_strobe (ld_strobe),
        .ld_value  (ld_value),
        .ch_mode   (ch_mode),
        .ch_bcd    (ch_bcd)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk);
        #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic ctrl(input logic [1:0] ch, input logic [1:0] acc, input logic [2:0] md, input logic b);
        wr(2'd3, {ch, acc, md, b});
    endtask

    task automatic expect_load(input logic [1:0] ch, input logic [15:0] v, input string tag);
        exp_ldc.push_back(ch);
        exp_ldv.push_back(v);
        ld_tag.push_back(tag);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_rd.push_back(e);
        rd_tag.push_back(tag);
        @(posedge clk);
        #1 bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: pop expected read bytes and loads as the design produces them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rd) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R7 unexpected read", {8'h0, bus_rdata}, 16'h0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_rd.pop_front();
                    t = rd_tag.pop_front();
                    chk(bus_rdata == e, t, {8'h0, bus_rdata}, {8'h0, e});
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (ld_strobe[c]) begin
                    if (exp_ldv.size() == 0) begin
                        chk(1'b0, "R6 unexpected load", ld_value[c*16 +: 16], 16'h0);
                    end else begin
                        logic [1:0]  ec;
                        logic [15:0] ev;
                        string t;
                        ec = exp_ldc.pop_front();
                        ev = exp_ldv.pop_front();
                        t = ld_tag.pop_front();
                        chk(ec == 2'(c), {t, " channel"}, 16'(c), {14'h0, ec});
                        chk(ld_value[c*16 +: 16] == ev, t, ld_value[c*16 +: 16], ev);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        cnt[0] = 16'h1234;
        cnt[1] = 16'h5678;
        cnt[2] = 16'h9ABC;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of every channel
        for (int c = 0; c < NCH; c++) begin
            chk(ch_mode[c*3 +: 3] == 3'd3, "R1 mode", 16'(ch_mode[c*3 +: 3]), 16'd3);
            chk(ch_bcd[c] == 1'b0, "R1 bcd", 16'(ch_bcd[c]), 16'd0);
            chk(ld_value[c*16 +: 16] == 16'h0, "R1 reload", ld_value[c*16 +: 16], 16'h0);
        end
        chk(ld_strobe == '0, "R1 strobe", 16'(ld_strobe), 16'h0);
        rd(2'd0, 8'h34, "R1 low-only read");
        rd(2'd0, 8'h34, "R1 low-only read again");

        // R4: low-byte-only load on channel 1
        expect_load(2'd1, 16'h005A, "R4 low-only load");
        wr(2'd1, 8'h5A);

        // R8/R9: freeze channel 1 in low-only access
        ctrl(2'd1, 2'd0, 3'd0, 1'b0);
        cnt[1] = 16'h1111;
        rd(2'd1, 8'h78, "R8 frozen low");
        rd(2'd1, 8'h56, "R8 frozen high");
        rd(2'd1, 8'h11, "R9 live after freeze");
        rd(2'd1, 8'h11, "R9 live again");

        // R2/R5: program channel 2 high-only, mode 5, decimal
        ctrl(2'd2, 2'd2, 3'd5, 1'b1);
        @(negedge clk);
        chk(ch_mode[8:6] == 3'd5, "R2 mode", 16'(ch_mode[8:6]), 16'd5);
        chk(ch_bcd[2] == 1'b1, "R2 bcd", 16'(ch_bcd[2]), 16'd1);
        chk(ch_mode[2:0] == 3'd3, "R2 other channel", 16'(ch_mode[2:0]), 16'd3);
        expect_load(2'd2, 16'hC300, "R5 high-only load");
        wr(2'd2, 8'hC3);
        rd(2'd2, 8'h9A, "R7 high-only read");
        rd(2'd2, 8'h9A, "R7 high-only read again");

        // R3: select value 3 is ignored
        wr(2'd3, 8'hFE);
        @(negedge clk);
        chk(ch_mode == {3'd5, 3'd3, 3'd3}, "R3 modes", 16'(ch_mode), 16'({3'd5, 3'd3, 3'd3}));
        chk(ch_bcd == 3'b100, "R3 bcd", 16'(ch_bcd), 16'h4);
        expect_load(2'd0, 16'h0011, "R3 access unchanged");
        wr(2'd0, 8'h11);

        // R6/R7: word access on channel 0
        ctrl(2'd0, 2'd3, 3'd2, 1'b0);
        wr(2'd0, 8'h78);
        expect_load(2'd0, 16'h5678, "R6 word load");
        wr(2'd0, 8'h56);
        wr(2'd0, 8'hAA);
        expect_load(2'd0, 16'hBBAA, "R6 word load repeats");
        wr(2'd0, 8'hBB);
        rd(2'd0, 8'h34, "R7 word low");
        rd(2'd0, 8'h12, "R7 word high");
        rd(2'd0, 8'h34, "R7 word low again");

        // R8/R9: freeze in word access, read order resumes afterwards
        ctrl(2'd0, 2'd0, 3'd7, 1'b1);
        cnt[0] = 16'h4321;
        @(negedge clk);
        chk(ch_mode[2:0] == 3'd2, "R8 mode kept", 16'(ch_mode[2:0]), 16'd2);
        chk(ch_bcd[0] == 1'b0, "R8 bcd kept", 16'(ch_bcd[0]), 16'd0);
        rd(2'd0, 8'h34, "R8 frozen low");
        rd(2'd0, 8'h12, "R8 frozen high");
        rd(2'd0, 8'h43, "R9 live high resumes");
        rd(2'd0, 8'h21, "R9 live low");

        // R10: control location reads 0xFF without side effects
        rd(2'd3, 8'hFF, "R10 control read");
        rd(2'd0, 8'h43, "R10 no side effect");

        // R11: reprogramming clears pending freeze and both orders
        wr(2'd0, 8'h99);
        rd(2'd0, 8'h21, "R11 setup read");
        ctrl(2'd0, 2'd0, 3'd0, 1'b0);
        cnt[0] = 16'h7788;
        ctrl(2'd0, 2'd3, 3'd0, 1'b0);
        @(negedge clk);
        chk(ch_mode[2:0] == 3'd0, "R11 mode", 16'(ch_mode[2:0]), 16'd0);
        rd(2'd0, 8'h88, "R11 freeze dropped, read low");
        rd(2'd0, 8'h77, "R11 read high");
        wr(2'd0, 8'h01);
        expect_load(2'd0, 16'h0201, "R11 write order restarted");
        wr(2'd0, 8'h02);

        repeat (4) @(posedge clk);
        chk(exp_rd.size() == 0, "R7 reads pending", 16'(exp_rd.size()), 16'h0);
        chk(exp_ldv.size() == 0, "R4 loads pending", 16'(exp_ldv.size()), 16'h0);
        finish_run();
    end

endmodule